// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns their exact `2W`-bit signed product. It uses Booth recoding at one bit per step. The caller presents a multiplicand and a multiplier and pulses `start` for one clock while the block is idle. The block then works for a fixed number of clocks and raises `done` for a single cycle. The product stays on its output until the next accepted start.

The datapath has four registers:
- an accumulator, one bit wider than the operands;
- a register holding the multiplier;
- an extra low bit that remembers the last bit shifted out of the multiplier;
- a step counter that starts at `W`.

A single adder/subtractor serves all steps, and a combinational arithmetic right shifter moves the accumulator, multiplier and extra bit as one word. On each step the block looks at the pair (multiplier bit 0, extra bit):
- pair 10: subtract the multiplicand from the accumulator, done as adding its inverse plus one;
- pair 01: add the multiplicand;
- pairs 00 and 11: leave the accumulator unchanged.

An arithmetic right shift of the whole word follows on the next clock. The step count drops by one with each shift.

The controller has four states:
- `ST_IDLE`: waits. `start` moves it to `ST_ARITH` and loads the operands (accumulator = 0, extra bit = 0, count = `W`).
- `ST_ARITH`: performs the add, subtract or hold, then always moves to `ST_SHIFT`.
- `ST_SHIFT`: shifts and decrements the count. It returns to `ST_ARITH` while steps remain, and goes to `ST_FINISH` after the last shift.
- `ST_FINISH`: raises `done` and always returns to `ST_IDLE`.

Top module: `booth_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: For any pair of signed `W`-bit operands, `product` holds their exact `2W`-bit two's-complement product when `done` is 1 (for example, 7 times 3 gives 21).
- R3: `busy` is 1 for exactly `2W` consecutive cycles following the clock edge that accepts `start`, and `busy` and `done` are never 1 together.
- R4: `done` is 1 for exactly one cycle, the cycle directly after the last busy cycle.
- R5: `product` stays unchanged from the `done` cycle until the next accepted start.
- R6: A `start` pulse while `busy` or `done` is 1 is ignored. The running operation completes with its original operands, and no new operation begins.
- R7: The extreme operand pairs give exact results without saturation: most-negative times most-negative, most-negative times 1, and most-positive times most-negative.
- R8: A step whose bit pair is 00 or 11 leaves the accumulator unchanged.
- R9: Each shift keeps the accumulator sign bit in place. The accumulator's low bit enters the top of the multiplier register, and the multiplier's bit 0 enters the extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request, accepted only when idle |
| mcand | input | W | Signed multiplicand, sampled when start is accepted |
| mplier | input | W | Signed multiplier, sampled when start is accepted |
| product | output | 2W | Signed product |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions rely on a few assumptions about the inputs:
- `rst` is synchronous and is held for at least one clock.
- The operands only matter in the cycle in which `start` is accepted.
- `start` may arrive in any state, and the design must filter it.

The stimulus stays within these assumptions. It changes operands and `start` only on falling edges. It also deliberately raises `start` in the middle of a run and in the `done` cycle, so that the ignore rule is exercised. A behavioural model tracks the expected phase and product every cycle, using plain integer multiplication.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARITH  = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_FINISH = 2'd3
    } booth_state_e;
endpackage

// File: rtl/booth_addsub.sv
module booth_addsub #(
    parameter int AW = 9
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] operand,
    input  logic          sub,
    output logic [AW-1:0] result
);
    logic [AW-1:0] opnd_x;
    always_comb begin
        opnd_x = operand ^ {AW{sub}};
        result = acc + opnd_x + AW'(sub);
    end
endmodule

// File: rtl/booth_shifter.sv
module booth_shifter #(
    parameter int W  = 8,
    parameter int AW = W + 1
) (
    input  logic [AW-1:0] acc_in,
    input  logic [W-1:0]  mq_in,
    output logic [AW-1:0] acc_out,
    output logic [W-1:0]  mq_out,
    output logic          ext_out
);
    always_comb begin
        acc_out = {acc_in[AW-1], acc_in[AW-1:1]};
        mq_out  = {acc_in[0], mq_in[W-1:1]};
        ext_out = mq_in[0];
    end
endmodule

// File: rtl/booth_seqcnt.sv
module booth_seqcnt #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    output logic          last,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= CW'(W);
        else if (dec)  count <= count - 1'b1;
    end

    assign last = (count == CW'(1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(W)); // R3
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dec && count == '0) |=> 1'b0); // R3
endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product,
    output logic           busy,
    output logic           done
);
    import booth_pkg::*;

    localparam int AW = W + 1;
    localparam int CW = $clog2(W + 1);

    booth_state_e state, state_nx;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] mc_q;
    logic [W-1:0]  mq_q;
    logic          ext_q;

    logic [AW-1:0] arith_res;
    logic [AW-1:0] sh_acc;
    logic [W-1:0]  sh_mq;
    logic          sh_ext;
    logic          cnt_last;
    logic [CW-1:0] cnt_val;
    logic          accept, do_shift, do_sub;
    logic [1:0]    pair;

    assign pair     = {mq_q[0], ext_q};
    assign do_sub   = (pair == 2'b10);
    assign accept   = (state == ST_IDLE) && start;
    assign do_shift = (state == ST_SHIFT);

    booth_addsub #(.AW(AW)) u_addsub (
        .acc     (acc_q),
        .operand (mc_q),
        .sub     (do_sub),
        .result  (arith_res)
    );

    booth_shifter #(.W(W), .AW(AW)) u_shift (
        .acc_in  (acc_q),
        .mq_in   (mq_q),
        .acc_out (sh_acc),
        .mq_out  (sh_mq),
        .ext_out (sh_ext)
    );

    booth_seqcnt #(.W(W), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .dec   (do_shift),
        .last  (cnt_last),
        .count (cnt_val)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ARITH;
            ST_ARITH:  state_nx = ST_SHIFT;
            ST_SHIFT:  state_nx = cnt_last ? ST_FINISH : ST_ARITH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_ARITH:  busy = 1'b1;
            ST_SHIFT:  busy = 1'b1;
            ST_FINISH: done = 1'b1;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mc_q  <= '0;
            mq_q  <= '0;
            ext_q <= 1'b0;
        end else if (accept) begin
            acc_q <= '0;
            mc_q  <= {mcand[W-1], mcand};
            mq_q  <= mplier;
            ext_q <= 1'b0;
        end else if (state == ST_ARITH) begin
            if (pair[1] ^ pair[0]) acc_q <= arith_res;
        end else if (do_shift) begin
            acc_q <= sh_acc;
            mq_q  <= sh_mq;
            ext_q <= sh_ext;
        end
    end

    assign product = {acc_q[W-1:0], mq_q};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R3
    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(product)); // R5
    AST_START_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !busy); // R6
    AST_PAIR_NOP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARITH && (mq_q[0] == ext_q)) |=> $stable(acc_q)); // R8
    AST_SHIFT_SIGN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |=> (acc_q[AW-1] == $past(acc_q[AW-1]))); // R9
    AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |=> (mq_q[W-1] == $past(acc_q[0]) && ext_q == $past(mq_q[0]))); // R9
endmodule

// File: tb/booth_mult_tb.sv
`timescale 1ns/1ps
module booth_mult_tb;
    localparam int W   = 8;
    localparam int LAT = 2 * W;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [W-1:0]   a, b;
    logic [2*W-1:0] product;
    logic           busy, done;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    booth_mult #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mcand(a), .mplier(b),
        .product(product), .busy(busy), .done(done)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return (2*W)'(sx * sy);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1..LAT running, LAT+1 done cycle
    int             phase;
    logic [2*W-1:0] exp_p;
    bit             have;

    always @(posedge clk) begin
        if (rst) begin
            phase <= 0;
            have  <= 1'b0;
            exp_p <= '0;
        end else if (phase == 0) begin
            if (start) begin
                phase <= 1;
                exp_p <= ref_mul(a, b);
                have  <= 1'b0;
            end
        end else if (phase == LAT + 1) begin
            phase <= 0;
            have  <= 1'b1;
        end else begin
            phase <= phase + 1;
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == (phase >= 1 && phase <= LAT), "R3 busy window", busy, (phase >= 1 && phase <= LAT));
            chk(done == (phase == LAT + 1), "R4 done pulse", done, (phase == LAT + 1));
            if (phase == LAT + 1)
                chk(product == exp_p, "R2 product at done", product, exp_p);
            else if (phase == 0 && have)
                chk(product == exp_p, "R5 product held", product, exp_p);
        end
    end

    task automatic mul(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        @(negedge clk);
        while (phase != 0) @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0; a = ~x; b = ~y;
        repeat (LAT) @(negedge clk);
        chk(done && product == ref_mul(x, y), tag, product, ref_mul(x, y));
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(product == '0, "R1 product after reset", product, 0);

        mul(8'd7,   8'd3,   "R2 7x3");
        mul(8'd0,   8'd99,  "R2 zero");
        mul(8'hFF,  8'hFF,  "R2 -1x-1");
        mul(8'd85,  8'hAA,  "R8 alternating bits");
        mul(8'hF0,  8'h0F,  "R8 runs of ones");
        mul(8'h80,  8'h80,  "R7 min x min");
        mul(8'h80,  8'd1,   "R7 min x 1");
        mul(8'h7F,  8'h80,  "R7 max x min");
        mul(8'h7F,  8'h7F,  "R7 max x max");
        repeat (4) @(negedge clk);
        chk(product == ref_mul(8'h7F, 8'h7F), "R5 product after idle", product, ref_mul(8'h7F, 8'h7F));

        // R6: start during busy with other operands
        @(negedge clk);
        a = 8'd12; b = 8'hF9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        a = 8'd100; b = 8'd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT - 6) @(negedge clk);
        chk(done && product == ref_mul(8'd12, 8'hF9), "R6 start while busy", product, ref_mul(8'd12, 8'hF9));
        // R6: start held during done cycle
        a = 8'd55; b = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R6 start in done cycle", busy, 0);
        repeat (3) @(negedge clk);
        chk(!busy && product == ref_mul(8'd12, 8'hF9), "R6 product kept", product, ref_mul(8'd12, 8'hF9));

        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] rx, ry;
            rx = W'($urandom);
            ry = W'($urandom);
            mul(rx, ry, "R2 random");
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule